// File: doc/BRIEF.md
# Interrupt Redirection Table with Selector/Window Access

This block holds the per-pin redirection table of an interrupt routing controller: one 64-bit entry for each of 24 input pins. Each entry carries a vector, a delivery mode, a destination mode, a delivery-status flag, an input polarity, a remote-IRR flag, a trigger mode, a mask bit and a destination ID. Software never addresses entries directly. It writes an 8-bit selector into a register at byte offset 0x00, then reads or writes the 32-bit data window at offset 0x10. Selector codes 0x00 to 0x02 reach an identification word, a fixed version word and an arbitration word. Codes from 0x10 upward reach the entries, two codes per entry: an even code selects the low half, an odd code the high half.

The pin service logic, which sits outside this block, reads every entry from a flat export bus. It sets or clears remote IRR through two per-pin strobes, and it reports which input lines it currently holds as asserted. A write can reconfigure an entry so that a pin is level-triggered, unmasked and still asserted. In that case the block issues a one-cycle re-service request naming that pin, so that the service logic delivers the pending level interrupt again.

Top module: `irq_redir_regfile`

## Requirements
- R1: After reset every entry equals 0x0000_0000_0001_0000 (only mask, bit 16, set), the selector and the identification field are zero, read data is zero and no re-service request is raised.
- R2: A write to offset 0x00 stores bits 7:0 as the selector, and a read of offset 0x00 returns the selector with bits 31:8 zero. Offset 0x04 and every offset other than 0x00 and 0x10 read as zero and ignore writes.
- R3: For selector values of 0x10 and above, the entry index is (selector − 0x10)/2 and selector bit 0 picks the half (1 = bits 63:32, 0 = bits 31:0). Read data appears on the cycle after read enable and is zero on every other cycle.
- R4: Window accesses whose selector is 0x03 to 0x0F, or whose decoded index is 24 or more, leave the table unchanged and read as zero.
- R5: A low-half write replaces bits 31:0 of the entry except delivery status (bit 12) and remote IRR (bit 14). Delivery status is never set by this block. A high-half write replaces bits 63:32.
- R6: A low-half write with trigger mode bit 15 = 0 (edge) clears remote IRR.
- R7: A service set strobe sets remote IRR only on a level-triggered entry (bit 15 = 1). A clear strobe clears it and takes priority over a set in the same cycle. Both strobes act before a software write in the same cycle.
- R8: After a write to either half of an entry, if the updated entry is level-triggered and unmasked (bit 16 = 0) and that pin's line is reported asserted, a re-service request is raised for exactly one cycle on the next cycle, carrying the pin index.
- R9: Selector 0x00 reaches a 4-bit identification field at bits 27:24 (other bits read zero). Selector 0x01 reads 0x0017_0011 (maximum index 23 in bits 23:16, version 0x11 in bits 7:0) and ignores writes. Selector 0x02 reads zero and ignores writes.
- R10: Entry i is exported on table_flat bits 64·i+63 down to 64·i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read enable |
| bus_offset | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| line_level | input | 24 | Lines currently recorded as asserted by the service logic |
| rirr_set | input | 24 | Per-pin remote-IRR set strobes |
| rirr_clr | input | 24 | Per-pin remote-IRR clear strobes |
| table_flat | output | 1536 | All entries, entry i at bits 64·i+63:64·i |
| resvc_valid | output | 1 | One-cycle re-service request |
| resvc_pin | output | 5 | Pin index of the re-service request |

## Verification
On every cycle the assertions check the following. Read data is zero unless a read was issued one cycle before. No edge-triggered entry ever holds remote IRR, and delivery status never becomes set. A re-service request only follows a window write, names a real pin, and points at an entry that is level-triggered and unmasked. A window write aimed past the last entry leaves the table unchanged. The decode arithmetic is shown only by the bench: it writes every one of the 256 selector codes and reads each back against an arithmetic model. So are the exact preservation of remote IRR across low-half writes, the clear-over-set priority, and the pulse/no-pulse outcomes for masked, edge and deasserted pins.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int ENTRY_W = 64;

    // Entry field layout, MSB first; bit positions are decoded by the service logic.
    typedef struct packed {
        logic [7:0]  dest;       // 63:56
        logic [38:0] rsvd;       // 55:17
        logic        mask;       // 16
        logic        trig;       // 15, 1 = level
        logic        rirr;       // 14
        logic        pol;        // 13
        logic        dstat;      // 12
        logic        dst_mode;   // 11
        logic [2:0]  dlv_mode;   // 10:8
        logic [7:0]  vector;     // 7:0
    } redir_entry_t;

    localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        SK_ID,
        SK_VER,
        SK_ARB,
        SK_ENTRY,
        SK_NONE
    } sel_kind_e;

endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int WIN_BASE = 16,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic [7:0]       sel,
    output sel_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);

    logic [8:0] rel;
    logic [6:0] idx_full;
    logic       in_range;

    assign rel      = {1'b0, sel} - 9'(WIN_BASE);
    assign idx_full = rel[7:1];
    assign in_range = !rel[8] && (32'(idx_full) < NUM_PINS);
    assign idx      = idx_full[IDX_W-1:0];
    assign hi       = rel[0];

    always_comb begin
        if (in_range) begin
            kind = SK_ENTRY;
        end else begin
            case (sel)
                8'h00:   kind = SK_ID;
                8'h01:   kind = SK_VER;
                8'h02:   kind = SK_ARB;
                default: kind = SK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [31:0]  wdata,
    input  logic         svc_set,
    input  logic         svc_clr,
    output redir_entry_t ent_q,
    output redir_entry_t ent_d
);

    logic         rirr_svc;
    logic [63:0]  raw;

    always_comb begin
        // service strobes act first; set only honoured on level entries, clear wins
        rirr_svc = (ent_q.rirr | (svc_set & ent_q.trig)) & ~svc_clr;
        raw = ent_q;
        if (wr_lo) begin
            raw[31:0] = wdata;
        end
        if (wr_hi) begin
            raw[63:32] = wdata;
        end
        ent_d       = raw;
        ent_d.dstat = ent_q.dstat;
        ent_d.rirr  = rirr_svc;
        if (wr_lo && !wdata[15]) begin
            ent_d.rirr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= redir_entry_t'(ENTRY_RST);
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
    import irq_redir_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          WIN_BASE = 16,
    parameter int          ID_LSB   = 24,
    parameter int          ID_W     = 4,
    parameter logic [7:0]  VER_CODE = 8'h11,
    localparam int         IDX_W    = $clog2(NUM_PINS),
    localparam int         FLAT_W   = NUM_PINS * ENTRY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [7:0]        bus_offset,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_PINS-1:0] line_level,
    input  logic [NUM_PINS-1:0] rirr_set,
    input  logic [NUM_PINS-1:0] rirr_clr,
    output logic [FLAT_W-1:0] table_flat,
    output logic              resvc_valid,
    output logic [IDX_W-1:0]  resvc_pin
);

    localparam logic [7:0]  OFF_SEL = 8'h00;
    localparam logic [7:0]  OFF_PAD = 8'h04;
    localparam logic [7:0]  OFF_WIN = 8'h10;
    localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VER_CODE};

    typedef struct packed {
        logic [7:0]       sel;
        logic [ID_W-1:0]  id;
        logic [31:0]      rdata;
        logic             pv;
        logic [IDX_W-1:0] pin;
    } top_state_t;

    top_state_t st_q, st_d;

    sel_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             hi;
    logic             win_wr;
    logic [31:0]      win_val;
    logic [31:0]      rd_val;
    logic [7:0]       sel_q;

    redir_entry_t ent_q [NUM_PINS];
    redir_entry_t ent_d [NUM_PINS];

    assign sel_q  = st_q.sel;
    assign win_wr = bus_we && (bus_offset == OFF_WIN);

    irq_redir_decode #(
        .NUM_PINS (NUM_PINS),
        .WIN_BASE (WIN_BASE),
        .IDX_W    (IDX_W)
    ) u_dec (
        .sel  (st_q.sel),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        logic wr_lo_i, wr_hi_i;
        assign wr_lo_i = win_wr && (kind == SK_ENTRY) && (idx == IDX_W'(i)) && !hi;
        assign wr_hi_i = win_wr && (kind == SK_ENTRY) && (idx == IDX_W'(i)) && hi;

        irq_redir_entry u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (wr_lo_i),
            .wr_hi   (wr_hi_i),
            .wdata   (bus_wdata),
            .svc_set (rirr_set[i]),
            .svc_clr (rirr_clr[i]),
            .ent_q   (ent_q[i]),
            .ent_d   (ent_d[i])
        );

        assign table_flat[ENTRY_W*i +: ENTRY_W] = ent_q[i];
    end

    // window read value
    always_comb begin
        win_val = '0;
        case (kind)
            SK_ID:    win_val[ID_LSB +: ID_W] = st_q.id;
            SK_VER:   win_val = VERSION_WORD;
            SK_ENTRY: begin
                if (hi) begin
                    win_val = ent_q[idx][63:32];
                end else begin
                    win_val = ent_q[idx][31:0];
                end
            end
            default:  win_val = '0;
        endcase
    end

    always_comb begin
        case (bus_offset)
            OFF_SEL: rd_val = {24'h0, st_q.sel};
            OFF_PAD: rd_val = '0;
            OFF_WIN: rd_val = win_val;
            default: rd_val = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.pv    = 1'b0;
        if (bus_we && (bus_offset == OFF_SEL)) begin
            st_d.sel = bus_wdata[7:0];
        end
        if (win_wr && (kind == SK_ID)) begin
            st_d.id = bus_wdata[ID_LSB +: ID_W];
        end
        if (bus_re) begin
            st_d.rdata = rd_val;
        end
        if (win_wr && (kind == SK_ENTRY) && line_level[idx]
            && ent_d[idx].trig && !ent_d[idx].mask) begin
            st_d.pv  = 1'b1;
            st_d.pin = idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign resvc_valid = st_q.pv;
    assign resvc_pin   = st_q.pin;

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS),
    localparam int FLAT_W  = NUM_PINS * 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic                bus_re,
    input logic [7:0]          bus_offset,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] rirr_set,
    input logic [NUM_PINS-1:0] rirr_clr,
    input logic [FLAT_W-1:0]   table_flat,
    input logic                resvc_valid,
    input logic [IDX_W-1:0]    resvc_pin,
    input logic [7:0]          sel_q
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bus_re)) |-> (bus_rdata == 32'h0));

    // R2
    sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_re && bus_offset == 8'h00)) |-> (bus_rdata[31:8] == 24'h0));

    // R8
    resvc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resvc_valid |-> (past_ok && $past(bus_we && bus_offset == 8'h10)));

    // R8
    resvc_pin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resvc_valid |-> (32'(resvc_pin) < NUM_PINS));

    // R8
    resvc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resvc_valid |-> (table_flat[64*resvc_pin + 15] && !table_flat[64*resvc_pin + 16]));

    // R4
    far_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_we && bus_offset == 8'h10 && sel_q >= 8'(16 + 2*NUM_PINS))
         && $past(rirr_set == '0 && rirr_clr == '0)) |-> $stable(table_flat));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R6
        edge_no_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !table_flat[64*i + 15] |-> !table_flat[64*i + 14]);
        // R5
        dstat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !table_flat[64*i + 12]);
    end

endmodule

bind irq_redir_regfile irq_redir_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_offset (bus_offset),
    .bus_rdata  (bus_rdata),
    .rirr_set   (rirr_set),
    .rirr_clr   (rirr_clr),
    .table_flat (table_flat),
    .resvc_valid(resvc_valid),
    .resvc_pin  (resvc_pin),
    .sel_q      (sel_q)
);

// File: tb/sim_irq_redir_regfile.sv
`timescale 1ns/1ps
module sim_irq_redir_regfile;

    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [7:0]    bus_offset = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] line_level = '0;
    logic [NP-1:0] rirr_set = '0;
    logic [NP-1:0] rirr_clr = '0;
    logic [NP*64-1:0] table_flat;
    logic          resvc_valid;
    logic [4:0]    resvc_pin;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;
    logic [63:0] mdl [NP];
    logic [3:0]  id_m = '0;
    logic        last_pv;
    logic [4:0]  last_pin;
    logic [31:0] rd;

    always #2 clk = ~clk;

    irq_redir_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_level(line_level), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .table_flat(table_flat), .resvc_valid(resvc_valid), .resvc_pin(resvc_pin)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_offset = off; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        last_pv = resvc_valid;
        last_pin = resvc_pin;
    endtask

    task automatic bus_read(input logic [7:0] off, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_offset = off;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic strobe(input logic [NP-1:0] s, input logic [NP-1:0] c);
        @(negedge clk);
        rirr_set = s; rirr_clr = c;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
    endtask

    // model of a window write with selector sel (requirements R3..R7, R9)
    task automatic mdl_write(input logic [7:0] sel, input logic [31:0] v);
        int ix;
        if (sel == 8'h00) id_m = v[27:24];
        if (sel >= 8'h10) begin
            ix = (int'(sel) - 16) / 2;
            if (ix < NP) begin
                if (sel[0]) mdl[ix][63:32] = v;
                else begin
                    mdl[ix][31:0] = {v[31:15], mdl[ix][14], v[13], mdl[ix][12], v[11:0]};
                    if (!v[15]) mdl[ix][14] = 1'b0;
                end
            end
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] sel);
        int ix;
        if (sel == 8'h00) return {4'h0, id_m, 24'h0};
        if (sel == 8'h01) return 32'h0017_0011;
        if (sel < 8'h10) return 32'h0;
        ix = (int'(sel) - 16) / 2;
        if (ix >= NP) return 32'h0;
        return sel[0] ? mdl[ix][63:32] : mdl[ix][31:0];
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) mdl[i] = 64'h0000_0000_0001_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NP; i++)
            chk(table_flat[64*i +: 64] == 64'h1_0000, "R1 entry reset", table_flat[64*i +: 64], 64'h1_0000);
        chk(bus_rdata == 0 && resvc_valid == 0, "R1 outputs idle", {bus_rdata, 31'h0, resvc_valid}, 64'h0);
        bus_read(8'h00, rd);
        chk(rd == 0, "R1 selector zero", rd, 0);

        // sweep: write every selector code
        for (int s = 0; s < 256; s++) begin
            logic [7:0]  sb;
            logic [31:0] v;
            sb = 8'(s);
            v  = {sb ^ 8'hC3, ~sb, sb, sb ^ 8'h3C};
            bus_write(8'h00, {24'h0, sb});
            bus_write(8'h10, v);
            mdl_write(sb, v);
            chk(last_pv == 0, "R8 no pulse with lines low", last_pv, 0);
        end
        // R3 R4 R9 read back every selector code
        for (int s = 0; s < 256; s++) begin
            bus_write(8'h00, 32'(s));
            bus_read(8'h10, rd);
            chk(rd == exp_read(8'(s)), "R3/R4/R9 window read", rd, exp_read(8'(s)));
        end
        // R10 export
        for (int i = 0; i < NP; i++)
            chk(table_flat[64*i +: 64] == mdl[i], "R10 flat export", table_flat[64*i +: 64], mdl[i]);

        // R3 read data returns to zero
        @(negedge clk);
        chk(bus_rdata == 0, "R3 rdata idle", bus_rdata, 0);

        // entry 5 low half: selector 0x1A
        bus_write(8'h00, 32'h1A);
        bus_write(8'h10, 32'h0000_8041);
        chk(last_pv == 0, "R8 no pulse line low", last_pv, 0);
        strobe(NP'(1) << 5, '0);
        bus_read(8'h10, rd);
        chk(rd == 32'h0000_C041, "R7 set on level", rd, 32'h0000_C041);
        bus_write(8'h10, 32'h0000_B041);
        bus_read(8'h10, rd);
        chk(rd == 32'h0000_E041, "R5 keep rirr and dstat", rd, 32'h0000_E041);
        strobe(NP'(1) << 5, NP'(1) << 5);
        bus_read(8'h10, rd);
        chk(rd == 32'h0000_A041, "R7 clear wins", rd, 32'h0000_A041);
        strobe(NP'(1) << 5, '0);
        bus_write(8'h10, 32'h0000_2041);
        bus_read(8'h10, rd);
        chk(rd == 32'h0000_2041, "R6 edge clears rirr", rd, 32'h0000_2041);

        // entry 6 edge: set ignored
        bus_write(8'h00, 32'h1C);
        bus_write(8'h10, 32'h0000_0033);
        strobe(NP'(1) << 6, '0);
        bus_read(8'h10, rd);
        chk(rd == 32'h0000_0033, "R7 set ignored on edge", rd, 32'h0000_0033);

        // R8 re-service
        line_level = NP'(1) << 5;
        bus_write(8'h00, 32'h1A);
        bus_write(8'h10, 32'h0001_8041);
        chk(last_pv == 0, "R8 masked no pulse", last_pv, 0);
        bus_write(8'h10, 32'h0000_0041);
        chk(last_pv == 0, "R8 edge no pulse", last_pv, 0);
        bus_write(8'h10, 32'h0000_8041);
        chk(last_pv == 1 && last_pin == 5, "R8 pulse pin 5", {last_pv, last_pin}, {1'b1, 5'd5});
        @(negedge clk);
        chk(resvc_valid == 0, "R8 pulse one cycle", resvc_valid, 0);
        bus_write(8'h00, 32'h1B);
        bus_write(8'h10, 32'h3400_0000);
        chk(last_pv == 1 && last_pin == 5, "R8 pulse on high write", {last_pv, last_pin}, {1'b1, 5'd5});
        line_level = NP'(1) << 4;
        bus_write(8'h10, 32'h3500_0000);
        chk(last_pv == 0, "R8 other line no pulse", last_pv, 0);
        line_level = '0;

        // R2 offsets
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        chk(rd == 0, "R2 pad offset zero", rd, 0);
        bus_read(8'h00, rd);
        chk(rd == 32'h1B, "R2 pad write ignored", rd, 32'h1B);
        bus_write(8'h00, 32'hABCD_EF1A);
        bus_read(8'h00, rd);
        chk(rd == 32'h1A, "R2 selector upper zero", rd, 32'h1A);
        bus_write(8'h08, 32'h0000_0055);
        bus_read(8'h08, rd);
        chk(rd == 0, "R2 unlisted offset", rd, 0);
        bus_read(8'h00, rd);
        chk(rd == 32'h1A, "R2 unlisted write ignored", rd, 32'h1A);

        // R9 id and version
        bus_write(8'h00, 32'h01);
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, rd);
        chk(rd == 32'h0017_0011, "R9 version fixed", rd, 32'h0017_0011);
        bus_write(8'h00, 32'h00);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, rd);
        chk(rd == 32'h0F00_0000, "R9 id field", rd, 32'h0F00_0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule